// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block receives configuration words over a three-wire serial port made of a shift clock, a data line and a load strobe. All three pins are asynchronous to the system clock. Each one passes through a two-stage synchronizer, and the block acts on the edges it sees in the system clock domain.

Every rising edge of the serial clock shifts one data bit into a 24-bit word, most significant bit first. A rising edge on the load strobe commits that word into one of four 24-bit holding registers. The two lowest bits of the word pick the register.

The register at address 01 holds the reference-divider setup. Its fields are decoded and driven onto dedicated pins. A word that would set the reference divide value to zero is refused and raises an error flag. Every commit produces a single-cycle update pulse for the register it wrote.

The serial interface is a plain pin protocol with no handshake and no back-pressure. The host keeps the data line steady while the serial clock rises and keeps the pulses apart from each other. The decoded outputs are plain level signals.

Top module: `serial_cfg_port`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_dat` into a 24-bit word, most significant bit first. The last bit shifted in becomes bit 0.
- R2: On a commit, the word's bits 1:0 select the destination register (00, 01, 10 or 11). Only that register takes the full 24-bit word. `cfg_words` carries register k at bits 24k+23 down to 24k.
- R3: A commit happens only on a rising edge of `ser_load`. Holding `ser_load` high or low while bits are shifted commits nothing. Each accepted commit raises `upd_stb[k]` for register k for exactly one cycle.
- R4: The reference register (address 01) is decoded as follows: divide value = bits 15:2, anti-backlash code = bits 17:16, lock-detect precision = bit 18, test bit = bit 19, band-clock code = bits 21:20.
- R5: Bits 23:22 of the reference register do not affect any decoded output.
- R6: `band_div` is the band-clock division factor. Codes 00, 01, 10 and 11 give the one-hot values 1, 2, 4 and 8.
- R7: A commit to address 01 whose bits 15:2 are all zero is refused. All registers keep their values, no update pulse is raised, and `div_err` goes high. `div_err` clears on the next accepted commit to address 01. Commits to the other addresses never check bits 15:2.
- R8: During and after reset, all registers and decoded fields are zero, `band_div` is 1, and `upd_stb` and `div_err` are low.
- R9: A rising edge of `ser_load` that is present at one system clock rising edge updates the registers, `upd_stb` and `div_err` at the third rising edge counting that one. A rising edge of `ser_clk` has its shift applied with the same delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_load | input | 1 | Serial load strobe, asynchronous |
| ref_div | output | 14 | Reference divide value |
| ref_abw | output | 2 | Anti-backlash width code |
| ref_ldp | output | 1 | Lock-detect precision bit |
| ref_test | output | 1 | Test mode bit |
| band_div | output | 4 | One-hot band-clock division factor |
| upd_stb | output | 4 | One-cycle update pulse per register |
| div_err | output | 1 | Refused zero-divide commit flag |
| cfg_words | output | 96 | All four holding registers, packed |

## Verification
Every serial pin edge reaches the outputs through a fixed pipeline. A pin value present at system clock edge t is captured by the first synchronizer stage and reaches the second stage at edge t+1. The edge detector fires between t+1 and t+2, so the registers, `upd_stb` and `div_err` all change at edge t+2, the third edge counting t.

The reference model in the bench keeps a short history of the pins sampled at each rising edge. At every edge it applies the shift or commit whose pin edge was present two edges earlier. All outputs are compared on the falling edge that follows, so each result is checked in the exact cycle it is due, and a one-cycle pulse that comes early or late is reported as a mismatch.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int unsigned WORD_W   = 24;
  localparam int unsigned N_REGS   = 4;
  localparam int unsigned ADDR_W   = $clog2(N_REGS);
  localparam int unsigned DIV_W    = 14;
  localparam logic [ADDR_W-1:0] REF_ADDR = 2'b01;

  // Layout of the reference register, most significant field first.
  typedef struct packed {
    logic [1:0]       spare;
    logic [1:0]       band_code;
    logic             test_bit;
    logic             ldp;
    logic [1:0]       abw;
    logic [DIV_W-1:0] div;
    logic [ADDR_W-1:0] addr;
  } ref_word_t;
endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_sync,
  output logic [W-1:0] pin_rise
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], pin_in[b]};
    end
    assign pin_sync[b] = chain[STAGES-1];
    assign pin_rise[b] = chain[STAGES-1] & ~chain[STAGES];
  end
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[W-2:0], bit_in};
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic [WORD_W-1:0]        word_in,
  output logic [N_REGS*WORD_W-1:0] regs_flat,
  output logic [N_REGS-1:0]        upd,
  output logic                     err
);
  localparam int unsigned DIV_LO = ADDR_W;
  localparam int unsigned DIV_HI = ADDR_W + DIV_W - 1;

  logic [WORD_W-1:0] regs [N_REGS];
  logic [ADDR_W-1:0] addr;
  logic              is_ref;
  logic              div_zero;
  logic              refuse;

  assign addr     = word_in[ADDR_W-1:0];
  assign is_ref   = (addr == REF_ADDR);
  assign div_zero = (word_in[DIV_HI:DIV_LO] == '0);
  assign refuse   = is_ref && div_zero;

  for (genvar k = 0; k < N_REGS; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[k] <= '0;
        upd[k]  <= 1'b0;
      end else begin
        upd[k] <= 1'b0;
        if (commit && !refuse && addr == ADDR_W'(k)) begin
          regs[k] <= word_in;
          upd[k]  <= 1'b1;
        end
      end
    end
    assign regs_flat[k*WORD_W +: WORD_W] = regs[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                err <= 1'b0;
    else if (commit && is_ref) err <= div_zero;
  end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import cfg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ser_clk,
  input  logic                     ser_dat,
  input  logic                     ser_load,
  output logic [DIV_W-1:0]         ref_div,
  output logic [1:0]               ref_abw,
  output logic                     ref_ldp,
  output logic                     ref_test,
  output logic [3:0]               band_div,
  output logic [N_REGS-1:0]        upd_stb,
  output logic                     div_err,
  output logic [N_REGS*WORD_W-1:0] cfg_words
);
  localparam int unsigned P_CLK = 0;
  localparam int unsigned P_DAT = 1;
  localparam int unsigned P_LD  = 2;

  logic [2:0]        pins_s;
  logic [2:0]        pins_r;
  logic [WORD_W-1:0] shift_word;
  ref_word_t         ref_w;

  cfg_pin_sync #(.W(3), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   ({ser_load, ser_dat, ser_clk}),
    .pin_sync (pins_s),
    .pin_rise (pins_r)
  );

  cfg_shifter #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (pins_r[P_CLK]),
    .bit_in   (pins_s[P_DAT]),
    .word     (shift_word)
  );

  cfg_reg_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (pins_r[P_LD]),
    .word_in   (shift_word),
    .regs_flat (cfg_words),
    .upd       (upd_stb),
    .err       (div_err)
  );

  assign ref_w    = ref_word_t'(cfg_words[int'(REF_ADDR)*WORD_W +: WORD_W]);
  assign ref_div  = ref_w.div;
  assign ref_abw  = ref_w.abw;
  assign ref_ldp  = ref_w.ldp;
  assign ref_test = ref_w.test_bit;
  assign band_div = 4'b0001 << ref_w.band_code;
endmodule

// File: rtl/serial_cfg_port_chk.sv
module serial_cfg_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  upd_stb,
  input logic        div_err,
  input logic [13:0] ref_div,
  input logic [3:0]  band_div,
  input logic [95:0] cfg_words
);
  // R3
  upd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_stb));
  // R3
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb != 4'b0) |=> (upd_stb == 4'b0));
  // R3
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb == 4'b0) |-> $stable(cfg_words));
  // R7
  ref_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb[1] |-> (ref_div != 14'd0));
  // R7
  refuse_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_err) |-> $stable(cfg_words));
  // R6
  band_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(band_div) == 1);
endmodule

bind serial_cfg_port serial_cfg_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_stb   (upd_stb),
  .div_err   (div_err),
  .ref_div   (ref_div),
  .band_div  (band_div),
  .cfg_words (cfg_words)
);

// File: tb/serial_cfg_port_tb.sv
module serial_cfg_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_load = 1'b0;
  logic [13:0] ref_div;
  logic [1:0]  ref_abw;
  logic        ref_ldp, ref_test;
  logic [3:0]  band_div;
  logic [3:0]  upd_stb;
  logic        div_err;
  logic [95:0] cfg_words;

  always #2.5 clk = ~clk;

  serial_cfg_port dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_load(ser_load), .ref_div(ref_div), .ref_abw(ref_abw),
    .ref_ldp(ref_ldp), .ref_test(ref_test), .band_div(band_div),
    .upd_stb(upd_stb), .div_err(div_err), .cfg_words(cfg_words)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit started = 0;

  // behavioural reference model
  bit q_clk[$], q_dat[$], q_ld[$];
  logic [23:0] m_shift = '0;
  logic [23:0] m_reg [4] = '{default: '0};
  logic [3:0]  m_upd = '0;
  bit          m_err = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [95:0] act, input logic [95:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q_clk = '{0, 0, 0}; q_dat = '{0, 0, 0}; q_ld = '{0, 0, 0};
      m_shift = '0; m_upd = '0; m_err = 0;
      for (int k = 0; k < 4; k++) m_reg[k] = '0;
      started = 1;
    end else begin
      // index 1 = value two edges ago, index 2 = three edges ago
      m_upd = '0;
      if (q_ld[1] && !q_ld[2]) begin
        int a;
        a = int'(m_shift[1:0]);
        if (a == 1 && m_shift[15:2] == 0) m_err = 1;
        else begin
          m_reg[a] = m_shift;
          m_upd[a] = 1'b1;
          if (a == 1) m_err = 0;
        end
      end
      if (q_clk[1] && !q_clk[2]) m_shift = {m_shift[22:0], q_dat[1]};
      q_clk.push_front(ser_clk); q_dat.push_front(ser_dat); q_ld.push_front(ser_load);
      void'(q_clk.pop_back()); void'(q_dat.pop_back()); void'(q_ld.pop_back());
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      logic [95:0] exp_words;
      logic [3:0]  exp_band;
      for (int k = 0; k < 4; k++) exp_words[k*24 +: 24] = m_reg[k];
      exp_band = 4'b0001 << m_reg[1][21:20];
      check(cfg_words == exp_words, "R1/R2 words", cfg_words, exp_words);
      check(upd_stb == m_upd, "R3/R9 upd_stb", 96'(upd_stb), 96'(m_upd));
      check({ref_test, ref_ldp, ref_abw, ref_div} == m_reg[1][19:2],
            "R4 fields", 96'({ref_test, ref_ldp, ref_abw, ref_div}),
            96'(m_reg[1][19:2]));
      check(band_div == exp_band, "R6 band_div", 96'(band_div), 96'(exp_band));
      check(div_err == m_err, "R7 div_err", 96'(div_err), 96'(m_err));
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      ser_dat = w[i];
      wait_cyc(3);
      ser_clk = 1'b1;
      wait_cyc(3);
      ser_clk = 1'b0;
    end
  endtask

  task automatic pulse_load();
    wait_cyc(3);
    ser_load = 1'b1;
    wait_cyc(4);
    ser_load = 1'b0;
    wait_cyc(4);
  endtask

  task automatic send(input logic [23:0] w);
    shift_bits(w);
    pulse_load();
  endtask

  function automatic logic [23:0] ref_word(input logic [1:0] spare,
      input logic [1:0] band, input bit tb, input bit ldp,
      input logic [1:0] abw, input logic [13:0] dv);
    return {spare, band, tb, ldp, abw, dv, 2'b01};
  endfunction

  initial begin
    logic [17:0] snap;
    wait_cyc(3);
    // R8 reset state
    check(cfg_words == '0 && upd_stb == 0 && !div_err && band_div == 4'b0001,
          "R8 reset", cfg_words, '0);
    rst_n = 1'b1;
    wait_cyc(3);
    send(ref_word(2'b00, 2'b11, 0, 1, 2'b10, 14'd5));      // R4, R6
    send(24'hA5C3_F0);                                     // R2 addr 00
    send(24'h3C_5A_96);                                    // R2 addr 10
    send(24'hFF_FF_FF);                                    // R2 addr 11
    send(24'h00_00_00);                                    // R7 zero ok on addr 00
    snap = {ref_test, ref_ldp, ref_abw, ref_div};
    send(ref_word(2'b11, 2'b11, 0, 1, 2'b10, 14'd5));      // R5 spare bits
    check({ref_test, ref_ldp, ref_abw, ref_div} == snap, "R5 spare ignored",
          96'({ref_test, ref_ldp, ref_abw, ref_div}), 96'(snap));
    send(ref_word(2'b00, 2'b01, 1, 0, 2'b01, 14'd0));      // R7 refused
    check(div_err && ref_div == 14'd5, "R7 refuse", 96'({div_err, ref_div}),
          96'({1'b1, 14'd5}));
    send(ref_word(2'b10, 2'b00, 0, 0, 2'b11, 14'h3FFF));   // R7 clears, R6
    send(ref_word(2'b01, 2'b10, 1, 1, 2'b00, 14'd1));      // R6 code 10
    // R3: load held high across a full word, no new rise
    ser_load = 1'b1;
    wait_cyc(4);
    shift_bits(24'h12_34_55);
    wait_cyc(4);
    ser_load = 1'b0;
    wait_cyc(6);
    check(cfg_words[47:24] == ref_word(2'b01, 2'b10, 1, 1, 2'b00, 14'd1),
          "R3 held load", 96'(cfg_words[47:24]), 96'(m_reg[1]));
    pulse_load();                                           // R1 commit of it
    check(cfg_words[47:24] == 24'h12_34_55, "R1 late commit",
          96'(cfg_words[47:24]), 96'h12_34_55);
    wait_cyc(4);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule